// File: doc/BRIEF.md
# Out-of-Band Burst/Gap Signal Detector

This block sits behind a serial link's squelch detector and turns a single-bit line-activity indication into out-of-band signal detections. The activity bit is sampled on a reference clock whose frequency does not depend on the negotiated link generation. The block measures every high run (a burst) and every low run (an idle gap) in reference-clock cycles and checks each against tolerance windows. All window limits are parameters given in picoseconds and converted to cycles from the clock period parameter. A lower limit rounds up to whole cycles and an upper limit rounds down.

All burst types share the same burst width, so the burst window only qualifies a burst. The signal class comes from the idle gap that follows each valid burst. A short gap marks a wake signal. A long gap marks the reset-type signal, which is reported as `cominit_det` when the receiver is a host and as `comreset_det` when it is a device. A detection is declared after four consecutive valid burst-gap pairs of the same class. Any timing violation raises a one-cycle error pulse and restarts the count. An idle period longer than the longest gap window ends the sequence quietly.

There is no data stream here. Every output is a single-cycle pulse with no back-pressure, so a consumer must take it in the cycle it appears.

Top module: `oob_gap_detector`

## Requirements
- R1: After reset, all four outputs are low, and they stay low until a burst-gap sequence has been received.
- R2: A burst is valid when its width in cycles is between ceil(BURST_LO_PS/CLK_PS) and floor(BURST_HI_PS/CLK_PS), inclusive. A burst of any other width pulses `timing_err` for one cycle and clears the pair count, so pairs received before it do not count toward a detection.
- R3: A gap that follows a valid burst and whose width lies in the wake window counts as a wake pair. The fourth consecutive wake pair pulses `comwake_det` for exactly one cycle. The pulse comes in the second clock cycle after the first clock edge that samples activity high at the end of the fourth gap.
- R4: A gap in the reset window counts as a reset-class pair, and the fourth such pair produces one pulse. With `is_host`=1 the pulse is on `cominit_det`, and with `is_host`=0 it is on `comreset_det`. The other reset-class output stays low.
- R5: A gap that follows a valid burst and is longer than zero but shorter than the gap timeout, yet inside neither gap window, pulses `timing_err` and clears the pair count.
- R6: A low run longer than the upper limit of the longest gap window ends the sequence. It clears the count and does not pulse `timing_err`, and the gap it belongs to is not classified.
- R7: A pair whose class differs from the previous pair restarts the count at one.
- R8: The count restarts after each detection, so eight consecutive same-class pairs yield exactly two pulses.
- R9: Burst width plays no part in classification. Valid bursts of different widths mix freely within one counted sequence.
- R10: Each pulse on the error and detection outputs lasts exactly one cycle. At most one of the four outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, independent of link speed |
| rst_n | input | 1 | Active-low synchronous reset |
| line_active | input | 1 | Squelch output: 1 during a burst, 0 when idle |
| is_host | input | 1 | Receiver role: 1 = host, 0 = device |
| comwake_det | output | 1 | One-cycle pulse: wake signal recognised |
| cominit_det | output | 1 | One-cycle pulse: reset-class signal recognised by a host |
| comreset_det | output | 1 | One-cycle pulse: reset-class signal recognised by a device |
| timing_err | output | 1 | One-cycle pulse: burst or gap outside every window |

## Verification
The bench runs a small configuration (5..6-cycle bursts and wake gaps, 15..17-cycle reset gaps) and sweeps the burst width and the gap width one cycle at a time across every window edge. An off-by-one in the cycle conversion or the comparison would shift a detection or an error to a neighbouring width. Sequences of three good pairs followed by a bad burst, a bad gap, a timeout or a class change, and then three more good pairs, catch a count that is not cleared: such a design would detect where none is expected. Both roles are exercised to catch a reset-class pulse on the wrong pin. An exact-cycle check on the wake pulse catches a missing or extra register stage.

// File: rtl/oob_det_pkg.sv
package oob_det_pkg;

  // Class of one idle gap following a valid burst
  typedef enum logic [1:0] {
    GAP_BAD  = 2'd0,
    GAP_WAKE = 2'd1,
    GAP_RST  = 2'd2
  } gap_cls_e;

  // Lower window edge in cycles: round up
  function automatic int ps_lo_cycles(input int lim_ps, input int clk_ps);
    return (lim_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Upper window edge in cycles: round down
  function automatic int ps_hi_cycles(input int lim_ps, input int clk_ps);
    return lim_ps / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/oob_run_meter.sv
// Measures high and low runs of the activity bit and flags over-long idle.
module oob_run_meter #(
  parameter int LIM = 326,   // saturation value of the run counter
  parameter int TMO = 324,   // longest legal gap; one more low sample ends the sequence
  parameter int LW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  output logic          run_end,
  output logic          run_was_burst,
  output logic [LW-1:0] run_len,
  output logic          idle_tmo
);

  logic          prev;
  logic [LW-1:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev          <= 1'b0;
      len           <= LW'(LIM);
      run_end       <= 1'b0;
      run_was_burst <= 1'b0;
      run_len       <= '0;
      idle_tmo      <= 1'b0;
    end else begin
      prev     <= act;
      run_end  <= (act != prev);
      idle_tmo <= 1'b0;
      if (act != prev) begin
        run_len       <= len;
        run_was_burst <= prev;
        len           <= LW'(1);
      end else begin
        if (len < LW'(LIM)) len <= len + LW'(1);
        if (!act && len == LW'(TMO)) idle_tmo <= 1'b1;
      end
    end
  end

  p_end_len_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |-> (run_len != '0));
  p_tmo_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_tmo |-> !$past(act));
  p_tmo_not_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_tmo && run_end));

endmodule

// File: rtl/oob_win_check.sv
// Compares a measured run length against the burst and gap windows.
module oob_win_check
  import oob_det_pkg::*;
#(
  parameter int B_LO = 104,
  parameter int B_HI = 109,
  parameter int W_LO = 104,
  parameter int W_HI = 109,
  parameter int R_LO = 310,
  parameter int R_HI = 324,
  parameter int LW   = 9
) (
  input  logic [LW-1:0] run_len,
  output logic          burst_ok,
  output gap_cls_e      gap_cls
);

  always_comb begin
    burst_ok = (run_len >= LW'(B_LO)) && (run_len <= LW'(B_HI));
    if ((run_len >= LW'(W_LO)) && (run_len <= LW'(W_HI)))
      gap_cls = GAP_WAKE;
    else if ((run_len >= LW'(R_LO)) && (run_len <= LW'(R_HI)))
      gap_cls = GAP_RST;
    else
      gap_cls = GAP_BAD;
  end

endmodule

// File: rtl/oob_pair_seq.sv
// Counts consecutive same-class burst/gap pairs and issues detections.
module oob_pair_seq
  import oob_det_pkg::*;
#(
  parameter int PAIRS = 4,
  parameter int CW    = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_end,
  input  logic     run_was_burst,
  input  logic     burst_ok,
  input  gap_cls_e gap_cls,
  input  logic     idle_tmo,
  output logic     det_wake,
  output logic     det_rst,
  output logic     tim_err
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  gap_cls_e      cls_q;
  logic          armed;   // a valid burst awaits its gap

  always_comb begin
    if (cnt != '0 && gap_cls != cls_q) cnt_inc = CW'(1);
    else                               cnt_inc = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cls_q    <= GAP_BAD;
      armed    <= 1'b0;
      det_wake <= 1'b0;
      det_rst  <= 1'b0;
      tim_err  <= 1'b0;
    end else begin
      det_wake <= 1'b0;
      det_rst  <= 1'b0;
      tim_err  <= 1'b0;
      if (idle_tmo) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (run_end && run_was_burst) begin
        if (burst_ok) begin
          armed <= 1'b1;
        end else begin
          armed   <= 1'b0;
          cnt     <= '0;
          tim_err <= 1'b1;
        end
      end else if (run_end && armed) begin
        armed <= 1'b0;
        if (gap_cls == GAP_BAD) begin
          cnt     <= '0;
          tim_err <= 1'b1;
        end else begin
          cls_q <= gap_cls;
          if (cnt_inc == CW'(PAIRS)) begin
            cnt      <= '0;
            det_wake <= (gap_cls == GAP_WAKE);
            det_rst  <= (gap_cls == GAP_RST);
          end else begin
            cnt <= cnt_inc;
          end
        end
      end
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PAIRS));
  p_det_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (det_wake || det_rst) |=> !(det_wake || det_rst));
  p_det_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (det_wake || det_rst) |-> $past(run_end));
  p_tmo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_tmo) |-> !tim_err);

endmodule

// File: rtl/oob_gap_detector.sv
module oob_gap_detector
  import oob_det_pkg::*;
#(
  parameter int CLK_PS     = 1000,
  parameter int BURST_LO_PS = 103500,
  parameter int BURST_HI_PS = 109900,
  parameter int WAKE_LO_PS  = 103500,
  parameter int WAKE_HI_PS  = 109900,
  parameter int RST_LO_PS   = 310000,
  parameter int RST_HI_PS   = 324000,
  parameter int PAIRS       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_active,
  input  logic is_host,
  output logic comwake_det,
  output logic cominit_det,
  output logic comreset_det,
  output logic timing_err
);

  localparam int B_LO  = ps_lo_cycles(BURST_LO_PS, CLK_PS);
  localparam int B_HI  = ps_hi_cycles(BURST_HI_PS, CLK_PS);
  localparam int W_LO  = ps_lo_cycles(WAKE_LO_PS, CLK_PS);
  localparam int W_HI  = ps_hi_cycles(WAKE_HI_PS, CLK_PS);
  localparam int R_LO  = ps_lo_cycles(RST_LO_PS, CLK_PS);
  localparam int R_HI  = ps_hi_cycles(RST_HI_PS, CLK_PS);
  localparam int TMO   = max2(W_HI, R_HI);
  localparam int LIM   = max2(TMO, B_HI) + 1;
  localparam int LW    = $clog2(LIM + 1);
  localparam int CW    = $clog2(PAIRS + 1);

  logic          run_end;
  logic          run_was_burst;
  logic [LW-1:0] run_len;
  logic          idle_tmo;
  logic          burst_ok;
  gap_cls_e      gap_cls;
  logic          det_rst;

  oob_run_meter #(.LIM(LIM), .TMO(TMO), .LW(LW)) u_meter (
    .clk(clk), .rst_n(rst_n), .act(line_active),
    .run_end(run_end), .run_was_burst(run_was_burst),
    .run_len(run_len), .idle_tmo(idle_tmo)
  );

  oob_win_check #(.B_LO(B_LO), .B_HI(B_HI), .W_LO(W_LO), .W_HI(W_HI),
                  .R_LO(R_LO), .R_HI(R_HI), .LW(LW)) u_win (
    .run_len(run_len), .burst_ok(burst_ok), .gap_cls(gap_cls)
  );

  oob_pair_seq #(.PAIRS(PAIRS), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_end(run_end),
    .run_was_burst(run_was_burst), .burst_ok(burst_ok),
    .gap_cls(gap_cls), .idle_tmo(idle_tmo),
    .det_wake(comwake_det), .det_rst(det_rst), .tim_err(timing_err)
  );

  assign cominit_det  = det_rst &  is_host;
  assign comreset_det = det_rst & ~is_host;

  p_one_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({comwake_det, cominit_det, comreset_det, timing_err}));
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> !timing_err);

endmodule

// File: tb/oob_gap_detector_test.sv
module oob_gap_detector_test;

  // Small configuration: clock 20 ns, burst and wake gap 5..6 cycles,
  // reset gap 15..17 cycles, timeout after 18 low cycles.
  localparam int CLK_PS = 20000;
  localparam int BLO = (100000 + CLK_PS - 1) / CLK_PS;
  localparam int BHI = 120000 / CLK_PS;
  localparam int RLO = (300000 + CLK_PS - 1) / CLK_PS;
  localparam int RHI = 340000 / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0;
  logic host = 1'b1;
  logic wk, ini, rs, er;

  int total = 0;
  int bad = 0;
  int n_wk = 0, n_ini = 0, n_rs = 0, n_er = 0;
  logic prev_any = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oob_gap_detector #(
    .CLK_PS(CLK_PS),
    .BURST_LO_PS(100000), .BURST_HI_PS(120000),
    .WAKE_LO_PS(100000),  .WAKE_HI_PS(120000),
    .RST_LO_PS(300000),   .RST_HI_PS(340000),
    .PAIRS(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_active(act), .is_host(host),
    .comwake_det(wk), .cominit_det(ini), .comreset_det(rs), .timing_err(er)
  );

  // Monitor: count pulses, check single-cycle width and exclusivity (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (wk) n_wk++;
      if (ini) n_ini++;
      if (rs) n_rs++;
      if (er) n_er++;
      if ((wk + ini + rs + er) > 1) begin
        total++; bad++;
        $display("FAIL R10: outputs %b%b%b%b high together, expected at most one", wk, ini, rs, er);
      end
      if (prev_any && (wk | ini | rs | er)) begin
        total++; bad++;
        $display("FAIL R10: pulse wider than one cycle, actual 2+ cycles expected 1");
      end
      prev_any <= wk | ini | rs | er;
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  task automatic pulse(input int b, input int g);
    act = 1'b1;
    repeat (b) @(negedge clk);
    act = 1'b0;
    repeat (g) @(negedge clk);
  endtask

  // last burst plus an idle long enough to time out
  task automatic tail();
    pulse(BLO, RHI + 8);
  endtask

  task automatic snap(output int a, output int b, output int c, output int d);
    a = n_wk; b = n_ini; c = n_rs; d = n_er;
  endtask

  task automatic expect_d(input string tag, input int w0, input int i0, input int r0, input int e0,
                          input int ew, input int ei, input int er_, input int ee);
    chk({tag, " wake"},  n_wk  - w0, ew);
    chk({tag, " init"},  n_ini - i0, ei);
    chk({tag, " reset"}, n_rs  - r0, er_);
    chk({tag, " err"},   n_er  - e0, ee);
  endtask

  initial begin
    int w0, i0, r0, e0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wake", wk, 0); chk("R1 init", ini, 0);
    chk("R1 reset", rs, 0); chk("R1 err", er, 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R1 quiet", n_wk + n_ini + n_rs + n_er, 0);

    // R2: burst width sweep, wake gaps
    for (int w = 1; w <= 20; w++) begin
      bit ok;
      ok = (w >= BLO) && (w <= BHI);
      snap(w0, i0, r0, e0);
      for (int k = 0; k < 4; k++) pulse(w, BLO);
      pulse(w, RHI + 8);
      expect_d($sformatf("R2 burst=%0d", w), w0, i0, r0, e0,
               ok ? 1 : 0, 0, 0, ok ? 0 : 5);
    end

    // R3/R4/R5/R6: gap width sweep for both roles
    for (int role = 1; role >= 0; role--) begin
      host = logic'(role);
      for (int g = 1; g <= RHI + 4; g++) begin
        bit wake_g, rst_g, tmo_g;
        wake_g = (g >= BLO) && (g <= BHI);
        rst_g  = (g >= RLO) && (g <= RHI);
        tmo_g  = (g > RHI);
        snap(w0, i0, r0, e0);
        for (int k = 0; k < 4; k++) pulse(BLO, g);
        tail();
        expect_d($sformatf("R3 R4 R5 R6 host=%0d gap=%0d", role, g), w0, i0, r0, e0,
                 wake_g ? 1 : 0,
                 (rst_g && role == 1) ? 1 : 0,
                 (rst_g && role == 0) ? 1 : 0,
                 (wake_g || rst_g || tmo_g) ? 0 : 4);
      end
    end
    host = 1'b1;

    // R3: exact cycle of the wake pulse
    for (int k = 0; k < 4; k++) pulse(BLO, BLO);
    act = 1'b1;
    @(negedge clk); chk("R3 timing edge+1", wk, 0);
    @(negedge clk); chk("R3 timing edge+2", wk, 1);
    @(negedge clk); chk("R3 timing edge+3", wk, 0);
    repeat (BLO - 3) @(negedge clk);
    act = 1'b0;
    repeat (RHI + 8) @(negedge clk);

    // R2: bad burst clears the count
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    pulse(BHI + 2, BLO);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    tail();
    expect_d("R2 clear", w0, i0, r0, e0, 0, 0, 0, 1);

    // R5: bad gap clears the count
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    pulse(BLO, BHI + 3);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    tail();
    expect_d("R5 clear", w0, i0, r0, e0, 0, 0, 0, 1);

    // R6: timeout clears the count without error
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    pulse(BLO, RHI + 3);
    for (int k = 0; k < 3; k++) pulse(BLO, BLO);
    tail();
    expect_d("R6 clear", w0, i0, r0, e0, 0, 0, 0, 0);

    // R7: class change restarts the count
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 2; k++) pulse(BLO, BLO);
    for (int k = 0; k < 3; k++) pulse(BLO, RLO);
    tail();
    expect_d("R7 short", w0, i0, r0, e0, 0, 0, 0, 0);
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 3; k++) pulse(BLO, RHI);
    for (int k = 0; k < 4; k++) pulse(BLO, BHI);
    tail();
    expect_d("R7 switch", w0, i0, r0, e0, 1, 0, 0, 0);

    // R8: eight pairs give two detections, device role
    host = 1'b0;
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 8; k++) pulse(BLO, RLO + 1);
    tail();
    expect_d("R8 repeat", w0, i0, r0, e0, 0, 0, 2, 0);
    host = 1'b1;

    // R9: mixed valid burst widths
    snap(w0, i0, r0, e0);
    for (int k = 0; k < 4; k++) pulse((k % 2 == 0) ? BLO : BHI, BLO);
    pulse(BHI, RHI + 8);
    expect_d("R9 mixed", w0, i0, r0, e0, 1, 0, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule